// File: doc/BRIEF.md
# Receive Destination Address Filter

The filter watches the first six bytes of an incoming Ethernet frame, which carry its destination address, and decides whether the frame is kept. It compares the address against the programmed station address. It recognises the all-ones broadcast address. For group (multicast) addresses it looks up one bit of a 64-bit hash table, and the CRC-32 of the address selects that bit.

A receive front end pulses `start_i` together with the first address byte. It then presents the remaining bytes with `byte_vld_i`, one byte per accepted cycle, and gaps between bytes are allowed. One cycle after the sixth byte, `done_o` rises with the verdict on `accept_o`. Both are held until the next `start_i`. Configuration comes in as static inputs: a receive enable, a promiscuous override, a broadcast-reject control, the station address split across two words, and two 32-bit hash words.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and in the cycle after any `start_i`, `done_o` and `accept_o` are 0.
- R2: `start_i` marks the cycle that carries destination byte 0. Bytes are taken on cycles with `byte_vld_i` high. The cycle after byte 5 is taken, `done_o` is 1 and `accept_o` carries the verdict. Bytes beyond the sixth are ignored.
- R3: The verdict and `done_o` hold unchanged until the next `start_i`.
- R4: When `rx_en_i` is 0 in the cycle that byte 5 is taken, the frame is rejected.
- R5: When receive is enabled and `promisc_i` is 1, every frame is accepted.
- R6: The address FF:FF:FF:FF:FF:FF is accepted when `bcast_rej_i` is 0 and rejected when it is 1. This applies unless R5 holds.
- R7: An address whose byte 0 has bit 0 set, and which is not broadcast, is a group address. The filter computes a CRC over the six address bytes. The CRC uses the polynomial 0x04C11DB7, starts from all ones, takes each byte LSB first, shifts MSB-out, and applies no final inversion. Bits [31:26] of the result form a 6-bit index. Index bit 5 picks `hash_hi_i` when set and `hash_lo_i` when clear. Index bits [4:0] pick the bit within that word. The frame is accepted when the selected bit is 1.
- R8: When both hash words are all ones, every group address is accepted.
- R9: Any other address is accepted only when it equals the station address. Byte 0 is `sta_hi_i[15:8]` and byte 1 is `sta_hi_i[7:0]`. Bytes 2 to 5 are `sta_lo_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| promisc_i | input | 1 | Accept all frames |
| bcast_rej_i | input | 1 | Reject broadcast frames |
| sta_lo_i | input | 32 | Station address bytes 2..5 |
| sta_hi_i | input | 16 | Station address bytes 0..1 |
| hash_lo_i | input | 32 | Hash bits for index 0..31 |
| hash_hi_i | input | 32 | Hash bits for index 32..63 |
| start_i | input | 1 | First destination byte strobe |
| byte_vld_i | input | 1 | Byte on byte_i is valid |
| byte_i | input | 8 | Destination address byte |
| done_o | output | 1 | Verdict valid |
| accept_o | output | 1 | Frame accepted |

## Verification
The bench uses random addresses of four kinds: the station address, the station address with one byte altered, random individual addresses and random group addresses. Each kind runs under random configurations and random gaps between bytes. Exact station matches against near misses show whether all 48 compare bits and their byte order are honoured. Random group addresses under random hash words show whether the CRC index and the word and bit selection are correct. Directed frames cover the overrides and the limits: broadcast with and without reject, promiscuous, receive off, all-ones hash, a single set hash bit in each word, bytes after the sixth, and a long idle period after the verdict.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[CRC_W-1] ^ d[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_addr_capture.sv
module rx_addr_capture #(
  parameter int unsigned N_BYTES = 6,
  localparam int unsigned CNT_W = $clog2(N_BYTES + 1),
  localparam int unsigned A_W   = 8 * N_BYTES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           byte_vld_i,
  input  logic [7:0]     byte_i,
  output logic           take_o,
  output logic           first_o,
  output logic           last_o,
  output logic [A_W-1:0] addr_o
);
  logic [CNT_W-1:0] cnt_q, idx;
  logic [A_W-1:0]   addr_q;

  assign idx     = start_i ? '0 : cnt_q;
  assign take_o  = byte_vld_i && (idx < CNT_W'(N_BYTES));
  assign first_o = start_i;
  assign last_o  = take_o && (idx == CNT_W'(N_BYTES - 1));
  assign addr_o  = {addr_q[A_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(N_BYTES);
      addr_q <= '0;
    end else begin
      if (take_o) begin
        cnt_q  <= idx + 1'b1;
        addr_q <= addr_o;
      end else if (start_i) begin
        cnt_q <= '0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_BYTES)); // R2
  AST_NO_TAKE_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == CNT_W'(N_BYTES)) |-> !take_o); // R2
endmodule

// File: rtl/rx_addr_crc.sv
module rx_addr_crc
  import rx_addr_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             first_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  assign crc_o = crc_byte(first_i ? CRC_SEED : crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (take_i) crc_q <= crc_o;
  end
endmodule

// File: rtl/rx_addr_decide.sv
module rx_addr_decide #(
  parameter int unsigned HASH_W = 32,
  localparam int unsigned A_W = 48,
  localparam int unsigned SEL_W = $clog2(HASH_W)
) (
  input  logic [A_W-1:0]    addr_i,
  input  logic [31:0]       crc_i,
  input  logic              rx_en_i,
  input  logic              promisc_i,
  input  logic              bcast_rej_i,
  input  logic [A_W-1:0]    station_i,
  input  logic [HASH_W-1:0] hash_lo_i,
  input  logic [HASH_W-1:0] hash_hi_i,
  output logic              accept_o
);
  logic             is_bcast, is_group;
  logic [SEL_W:0]   hidx;
  logic             hash_hit;

  assign is_bcast = &addr_i;
  assign is_group = addr_i[A_W-8] && !is_bcast;  // I/G bit of byte 0
  assign hidx     = crc_i[31 -: (SEL_W + 1)];
  assign hash_hit = hidx[SEL_W] ? hash_hi_i[hidx[SEL_W-1:0]]
                                : hash_lo_i[hidx[SEL_W-1:0]];

  always_comb begin
    if (!rx_en_i)      accept_o = 1'b0;
    else if (promisc_i) accept_o = 1'b1;
    else if (is_bcast) accept_o = !bcast_rej_i;
    else if (is_group) accept_o = hash_hit;
    else               accept_o = (addr_i == station_i);
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_en_i,
  input  logic        promisc_i,
  input  logic        bcast_rej_i,
  input  logic [31:0] sta_lo_i,
  input  logic [15:0] sta_hi_i,
  input  logic [31:0] hash_lo_i,
  input  logic [31:0] hash_hi_i,
  input  logic        start_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic        accept_o
);
  localparam int unsigned N_BYTES = 6;
  localparam int unsigned A_W     = 8 * N_BYTES;

  logic             take, first, last, accept_d;
  logic [A_W-1:0]   addr;
  logic [CRC_W-1:0] crc;

  rx_addr_capture #(.N_BYTES(N_BYTES)) u_capture (
    .clk_i, .rst_ni, .start_i, .byte_vld_i, .byte_i,
    .take_o(take), .first_o(first), .last_o(last), .addr_o(addr)
  );

  rx_addr_crc u_crc (
    .clk_i, .rst_ni, .take_i(take), .first_i(first), .byte_i, .crc_o(crc)
  );

  rx_addr_decide #(.HASH_W(32)) u_decide (
    .addr_i(addr), .crc_i(crc), .rx_en_i, .promisc_i, .bcast_rej_i,
    .station_i({sta_hi_i, sta_lo_i}), .hash_lo_i, .hash_hi_i,
    .accept_o(accept_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end else if (last) begin
      done_o   <= 1'b1;
      accept_o <= accept_d;
    end else if (start_i) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !last) |=> (!done_o && !accept_o)); // R1
  AST_VERDICT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(accept_o))); // R3
  AST_RX_OFF_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !rx_en_i) |=> !accept_o); // R4
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && rx_en_i && promisc_i) |=> accept_o); // R5
  AST_BCAST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && &addr && bcast_rej_i && !promisc_i) |=> !accept_o); // R6
  AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> done_o); // R2
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        rx_en = 0, promisc = 0, bcast_rej = 0;
  logic [31:0] sta_lo = 0, hash_lo = 0, hash_hi = 0;
  logic [15:0] sta_hi = 0;
  logic        start = 0, vld = 0;
  logic [7:0]  bt = 0;
  logic        done, accept;
  int          checks = 0, errors = 0;
  int          cycles = 0;
  logic        hung = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .promisc_i(promisc),
    .bcast_rej_i(bcast_rej), .sta_lo_i(sta_lo), .sta_hi_i(sta_hi),
    .hash_lo_i(hash_lo), .hash_hi_i(hash_hi), .start_i(start),
    .byte_vld_i(vld), .byte_i(bt), .done_o(done), .accept_o(accept)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ a[47 - 8*k - 7 + b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [5:0] ix;
    if (!rx_en) return 1'b0;
    if (promisc) return 1'b1;
    if (a == '1) return !bcast_rej;
    if (a[40]) begin
      ix = ref_idx(a);
      return ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]];
    end
    return a == {sta_hi, sta_lo};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive at negedge; gaps between bytes up to max_gap idle cycles
  task automatic send(input logic [47:0] a, input int max_gap);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      start = (k == 0);
      vld   = 1;
      bt    = a[47 - 8*k -: 8];
      if (k == 0) begin
        @(negedge clk);
        start = 0; vld = 0;
        check("R1 done cleared after start", done, 1'b0);
        check("R1 accept cleared after start", accept, 1'b0);
        continue;
      end
      if (k < 5 && max_gap > 0)
        repeat ($urandom_range(max_gap)) begin
          @(negedge clk); vld = 0; start = 0;
        end
    end
    @(negedge clk);
    vld = 0; start = 0;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input int max_gap);
    logic exp = ref_accept(a);
    send(a, max_gap);
    check({req, " done"}, done, 1'b1);
    check({req, " verdict"}, accept, exp);
  endtask

  function automatic logic [47:0] rand_addr();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    while (cycles < 150000) begin
      @(posedge clk); cycles++;
    end
    hung = 1;
  end

  initial begin
    logic [47:0] a, st;
    logic [5:0]  ix;
    void'($urandom(32'd1234));
    #(3*CLK_PERIOD);
    check("R1 reset done", done, 1'b0);
    check("R1 reset accept", accept, 1'b0);
    @(negedge clk); rst_n = 1;

    sta_hi = 16'h0A1B; sta_lo = 32'h2C3D_4E5F; st = {sta_hi, sta_lo};
    rx_en = 1;

    frame("R9 station match", st, 0);
    for (int k = 0; k < 6; k++) begin
      a = st ^ (48'h01 << (8*(5-k) + 3));
      frame("R9 one byte off", a, 2);
    end
    frame("R6 broadcast kept", '1, 0);
    bcast_rej = 1;
    frame("R6 broadcast rejected", '1, 1);
    promisc = 1;
    frame("R5 promisc broadcast", '1, 0);
    frame("R5 promisc unicast", 48'h0200_0000_0001, 3);
    promisc = 0; bcast_rej = 0;
    hash_lo = '1; hash_hi = '1;
    frame("R8 all ones group", 48'h0100_5E00_0001, 0);
    frame("R8 all ones group 2", 48'h3333_0000_00FB, 2);
    hash_lo = 0; hash_hi = 0;
    frame("R7 empty table", 48'h0100_5E00_0001, 0);
    // single bit set in each word at the computed index
    for (int n = 0; n < 8; n++) begin
      a = rand_addr(); a[40] = 1'b1; a[47] = 1'b0;
      ix = ref_idx(a);
      hash_lo = 0; hash_hi = 0;
      if (ix[5]) hash_hi[ix[4:0]] = 1'b1; else hash_lo[ix[4:0]] = 1'b1;
      frame("R7 single hash bit", a, 1);
      if (ix[5]) begin hash_hi = ~hash_hi; hash_lo = '1; end
      else       begin hash_lo = ~hash_lo; hash_hi = '1; end
      frame("R7 only that bit clear", a, 1);
    end
    hash_lo = 0; hash_hi = 0;
    rx_en = 0;
    frame("R4 rx off station", st, 0);
    promisc = 1;
    frame("R4 rx off promisc", st, 0);
    promisc = 0; rx_en = 1;

    // extra bytes after the sixth, then a long idle: verdict must hold
    frame("R2 station before extras", st, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); vld = 1; bt = 8'h00;
    end
    @(negedge clk); vld = 0;
    check("R2 extra bytes ignored done", done, 1'b1);
    check("R2 extra bytes ignored verdict", accept, 1'b1);
    repeat (20) @(negedge clk);
    check("R3 held done", done, 1'b1);
    check("R3 held verdict", accept, 1'b1);

    for (int n = 0; n < 300; n++) begin
      rx_en     = ($urandom_range(9) != 0);
      promisc   = ($urandom_range(7) == 0);
      bcast_rej = $urandom_range(1);
      hash_lo   = $urandom; hash_hi = $urandom;
      case ($urandom_range(4))
        0: a = st;
        1: a = st ^ (48'h1 << $urandom_range(47));
        2: a = '1;
        3: begin a = rand_addr(); a[40] = 1'b1; end
        default: begin a = rand_addr(); a[40] = 1'b0; end
      endcase
      if ($urandom_range(3) == 0) begin
        sta_hi = 16'($urandom); sta_hi[8] = 1'b0; sta_lo = $urandom;
        if ($urandom_range(1) == 1) a = {sta_hi, sta_lo};
        st = {sta_hi, sta_lo};
      end
      frame("R7 R9 random", a, 3);
      if (hung) break;
    end

    if (hung) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule